// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block is the purely combinational control core of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) in which up to five instructions are in flight, one per stage. From the opcodes and register identifiers held in the pipeline registers, and from the condition outcome resolved in execute, it produces in the same cycle the stall and bubble strobes for the front of the pipeline and the operand source selects for the decode-stage forwarding muxes.

Three hazards cost cycles. A load (memory-to-register move or stack pop) in execute whose loaded register is read by the decode instruction stalls the front end for one cycle while a bubble enters execute. A return instruction holds fetch while it travels through decode, execute and memory, which is three cycles, until its target has been read from the stack. Conditional jumps are predicted taken; when the jump in execute turns out not taken, the two younger instructions in decode and execute are replaced by bubbles and fetch resumes at the fall-through address carried with the jump. Every other data hazard is removed by forwarding, so it costs no cycle.

The block holds no state. The surrounding datapath registers the strobes and applies the selects.

Top module: `hazard_ctrl_top`

## Requirements
- R1: When the execute opcode is 4'h5 (memory load) or 4'hB (stack pop) and its memory destination register equals either decode source register, the outputs are fetchStall=1, decodeStall=1, decodeBubble=0, executeBubble=1.
- R2: Register ID 4'hF means "no register": it never produces a load/use stall and never matches a forwarding source, so a 4'hF source always selects the register file (select 0).
- R3: A load whose destination matches neither decode source, or a non-load execute instruction whose ALU destination matches a source, causes no stall or bubble; the value is forwarded instead.
- R4: An opcode of 4'h9 (return) in decode, execute or memory gives fetchStall=1, decodeBubble=1, decodeStall=0, executeBubble=0 when no other hazard is present.
- R5: When a load/use hazard and a return in decode occur together, decode is stalled and not bubbled: fetchStall=1, decodeStall=1, decodeBubble=0, executeBubble=1.
- R6: An execute opcode of 4'h7 (conditional jump) with the condition input at 0 gives decodeBubble=1 and executeBubble=1; with the condition at 1 it gives no bubble. A return in decode at the same time adds fetchStall=1.
- R7: Each operand select follows this priority, highest first, with its code: execute ALU result (1), memory read data (2), memory ALU result (3), writeback memory value (4), writeback ALU value (5), register file (0).
- R8: The two operand selects are decided independently of each other.
- R9: With no hazard present (all stages no-op, all registers 4'hF) every strobe is 0 and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| decIcode | input | 4 | Opcode of the instruction in decode |
| decSrcA | input | 4 | First source register read in decode |
| decSrcB | input | 4 | Second source register read in decode |
| exeIcode | input | 4 | Opcode of the instruction in execute |
| exeDstE | input | 4 | ALU-result destination of the execute instruction |
| exeDstM | input | 4 | Memory-result destination of the execute instruction |
| exeCnd | input | 1 | Condition outcome computed in execute |
| memIcode | input | 4 | Opcode of the instruction in memory |
| memDstE | input | 4 | ALU-result destination of the memory-stage instruction |
| memDstM | input | 4 | Memory-result destination of the memory-stage instruction |
| wbDstE | input | 4 | ALU-result destination of the writeback instruction |
| wbDstM | input | 4 | Memory-result destination of the writeback instruction |
| fetchStall | output | 1 | Hold the fetch-stage PC register |
| decodeStall | output | 1 | Hold the decode pipeline register |
| decodeBubble | output | 1 | Load a no-op into the decode pipeline register |
| executeBubble | output | 1 | Load a no-op into the execute pipeline register |
| fwdSelA | output | 3 | Source select for the first decode operand |
| fwdSelB | output | 3 | Source select for the second decode operand |

## Verification
A wrong hazard decision shows at the strobes in the very cycle the offending opcodes and register IDs are presented, since nothing is registered inside: a missed load/use match leaves decodeStall low while a load sits in execute, and a bad priority chain shows as the wrong select code as soon as two stages name the same register. The bench therefore presents stage contents that overlap on purpose (several destinations equal to one source, a return meeting a load or a wrong jump) and compares every strobe and both selects against hand-derived values. The cases where a 4'hF identifier sits on both sides of a comparison are covered separately, because that is where a missing guard would invent a hazard.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  parameter int REG_W = 4;
  parameter int OP_W  = 4;

  typedef logic [REG_W-1:0] regId_t;
  typedef logic [OP_W-1:0]  opcode_t;

  localparam regId_t  REG_NONE = '1;
  localparam opcode_t OP_NOP   = 4'h1;
  localparam opcode_t OP_LOAD  = 4'h5;
  localparam opcode_t OP_JUMP  = 4'h7;
  localparam opcode_t OP_RET   = 4'h9;
  localparam opcode_t OP_POP   = 4'hB;

  localparam int FWD_SRCS = 5;

  typedef enum logic [2:0] {
    FWD_RF      = 3'd0,
    FWD_EXE_ALU = 3'd1,
    FWD_MEM_RD  = 3'd2,
    FWD_MEM_ALU = 3'd3,
    FWD_WB_MEM  = 3'd4,
    FWD_WB_ALU  = 3'd5
  } fwdSel_t;

  typedef struct packed {
    logic loadUse;
    logic retPending;
    logic mispredict;
  } hazFlags_t;

  typedef struct packed {
    logic fStall;
    logic dStall;
    logic dBubble;
    logic eBubble;
  } stageCtl_t;
endpackage

// File: rtl/hazard_detect.sv
module hazard_detect
  import hzd_pkg::*;
(
  input  opcode_t   decIcode,
  input  regId_t    decSrcA,
  input  regId_t    decSrcB,
  input  opcode_t   exeIcode,
  input  regId_t    exeDstM,
  input  logic      exeCnd,
  input  opcode_t   memIcode,
  output hazFlags_t flags
);
  logic exeIsLoad;
  logic srcHit;

  always_comb begin
    exeIsLoad = (exeIcode == OP_LOAD) || (exeIcode == OP_POP);
    srcHit    = (exeDstM != REG_NONE) &&
                ((exeDstM == decSrcA) || (exeDstM == decSrcB));
    flags.loadUse    = exeIsLoad && srcHit;
    flags.retPending = (decIcode == OP_RET) || (exeIcode == OP_RET) ||
                       (memIcode == OP_RET);
    flags.mispredict = (exeIcode == OP_JUMP) && !exeCnd;
  end

  always_comb begin
    // R1
    if (flags.loadUse) begin
      load_excl_jump_chk: assert (!flags.mispredict)
        else $error("load/use and mispredict from one execute opcode");
    end
    // R2
    if (exeDstM == REG_NONE) begin
      none_no_loaduse_chk: assert (!flags.loadUse)
        else $error("register 0xF produced a load/use hazard");
    end
  end
endmodule

// File: rtl/stage_ctrl.sv
module stage_ctrl
  import hzd_pkg::*;
(
  input  hazFlags_t flags,
  output stageCtl_t ctl
);
  always_comb begin
    ctl.fStall  = flags.loadUse || flags.retPending;
    ctl.dStall  = flags.loadUse;
    ctl.dBubble = flags.mispredict || (flags.retPending && !flags.loadUse);
    ctl.eBubble = flags.mispredict || flags.loadUse;
  end

  always_comb begin
    // R5
    dec_stall_bubble_excl_chk: assert (!(ctl.dStall && ctl.dBubble))
      else $error("decode both stalled and bubbled");
    // R1
    if (ctl.dStall) begin
      stall_implies_front_chk: assert (ctl.fStall && ctl.eBubble)
        else $error("decode stall without fetch stall and execute bubble");
    end
    // R6
    if (flags.mispredict) begin
      squash_two_chk: assert (ctl.dBubble && ctl.eBubble && !ctl.dStall)
        else $error("mispredict did not squash both younger slots");
    end
  end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import hzd_pkg::*;
(
  input  regId_t  src,
  input  regId_t  exeDstE,
  input  regId_t  memDstM,
  input  regId_t  memDstE,
  input  regId_t  wbDstM,
  input  regId_t  wbDstE,
  output fwdSel_t sel
);
  regId_t  candDst  [FWD_SRCS];
  fwdSel_t candCode [FWD_SRCS];

  always_comb begin
    candDst[0] = exeDstE;  candCode[0] = FWD_EXE_ALU;
    candDst[1] = memDstM;  candCode[1] = FWD_MEM_RD;
    candDst[2] = memDstE;  candCode[2] = FWD_MEM_ALU;
    candDst[3] = wbDstM;   candCode[3] = FWD_WB_MEM;
    candDst[4] = wbDstE;   candCode[4] = FWD_WB_ALU;
    sel = FWD_RF;
    if (src != REG_NONE) begin
      for (int i = FWD_SRCS - 1; i >= 0; i--) begin
        if (candDst[i] == src) sel = candCode[i];
      end
    end
  end

  always_comb begin
    // R2
    if (src == REG_NONE) begin
      none_selects_rf_chk: assert (sel == FWD_RF)
        else $error("register 0xF was forwarded");
    end
    // R7
    if (src != REG_NONE && exeDstE == src) begin
      exe_wins_chk: assert (sel == FWD_EXE_ALU)
        else $error("execute result lost priority");
    end
  end
endmodule

// File: rtl/hazard_ctrl_top.sv
module hazard_ctrl_top
  import hzd_pkg::*;
(
  input  logic [3:0] decIcode,
  input  logic [3:0] decSrcA,
  input  logic [3:0] decSrcB,
  input  logic [3:0] exeIcode,
  input  logic [3:0] exeDstE,
  input  logic [3:0] exeDstM,
  input  logic       exeCnd,
  input  logic [3:0] memIcode,
  input  logic [3:0] memDstE,
  input  logic [3:0] memDstM,
  input  logic [3:0] wbDstE,
  input  logic [3:0] wbDstM,
  output logic       fetchStall,
  output logic       decodeStall,
  output logic       decodeBubble,
  output logic       executeBubble,
  output logic [2:0] fwdSelA,
  output logic [2:0] fwdSelB
);
  hazFlags_t flags;
  stageCtl_t ctl;
  regId_t    srcs [2];
  fwdSel_t   sels [2];

  hazard_detect u_detect (
    .decIcode (decIcode),
    .decSrcA  (decSrcA),
    .decSrcB  (decSrcB),
    .exeIcode (exeIcode),
    .exeDstM  (exeDstM),
    .exeCnd   (exeCnd),
    .memIcode (memIcode),
    .flags    (flags)
  );

  stage_ctrl u_ctrl (
    .flags (flags),
    .ctl   (ctl)
  );

  assign srcs[0] = decSrcA;
  assign srcs[1] = decSrcB;

  // R8: one independent selector per decode operand
  for (genvar g = 0; g < 2; g++) begin : g_fwd
    fwd_pick u_pick (
      .src     (srcs[g]),
      .exeDstE (exeDstE),
      .memDstM (memDstM),
      .memDstE (memDstE),
      .wbDstM  (wbDstM),
      .wbDstE  (wbDstE),
      .sel     (sels[g])
    );
  end

  assign fetchStall    = ctl.fStall;
  assign decodeStall   = ctl.dStall;
  assign decodeBubble  = ctl.dBubble;
  assign executeBubble = ctl.eBubble;
  assign fwdSelA       = sels[0];
  assign fwdSelB       = sels[1];
endmodule

// File: tb/hazard_ctrl_top_tb.sv
module hazard_ctrl_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;  // 50 MHz

  logic [3:0] decIcode, decSrcA, decSrcB, exeIcode, exeDstE, exeDstM;
  logic       exeCnd;
  logic [3:0] memIcode, memDstE, memDstM, wbDstE, wbDstM;
  logic       fetchStall, decodeStall, decodeBubble, executeBubble;
  logic [2:0] fwdSelA, fwdSelB;

  // shadow stimulus, copied onto the DUT inputs by the driver
  logic [3:0] sDI, sSA, sSB, sEI, sEDE, sEDM, sMI, sMDE, sMDM, sWDE, sWDM;
  logic       sCnd;

  hazard_ctrl_top u_dut (
    .decIcode(decIcode), .decSrcA(decSrcA), .decSrcB(decSrcB),
    .exeIcode(exeIcode), .exeDstE(exeDstE), .exeDstM(exeDstM), .exeCnd(exeCnd),
    .memIcode(memIcode), .memDstE(memDstE), .memDstM(memDstM),
    .wbDstE(wbDstE), .wbDstM(wbDstM),
    .fetchStall(fetchStall), .decodeStall(decodeStall),
    .decodeBubble(decodeBubble), .executeBubble(executeBubble),
    .fwdSelA(fwdSelA), .fwdSelB(fwdSelB)
  );

  typedef struct {
    logic [3:0] ctl;   // {fetchStall, decodeStall, decodeBubble, executeBubble}
    logic [2:0] selA;
    logic [2:0] selB;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic idle();
    sDI = 4'h1; sSA = 4'hF; sSB = 4'hF;
    sEI = 4'h1; sEDE = 4'hF; sEDM = 4'hF; sCnd = 1'b1;
    sMI = 4'h1; sMDE = 4'hF; sMDM = 4'hF;
    sWDE = 4'hF; sWDM = 4'hF;
  endtask

  task automatic send(input logic [3:0] ctl, input logic [2:0] a,
                      input logic [2:0] b, input string tag);
    expItem_t it;
    @(posedge clk);
    #1;
    decIcode = sDI; decSrcA = sSA; decSrcB = sSB;
    exeIcode = sEI; exeDstE = sEDE; exeDstM = sEDM; exeCnd = sCnd;
    memIcode = sMI; memDstE = sMDE; memDstM = sMDM;
    wbDstE = sWDE; wbDstM = sWDM;
    it.ctl = ctl; it.selA = a; it.selB = b; it.tag = tag;
    scoreQ.push_back(it);
    @(negedge clk);
    #1;
  endtask

  // monitor: pops one expected item per falling edge
  always @(negedge clk) begin
    if (!rst && scoreQ.size() > 0) begin
      expItem_t it;
      logic [3:0] got;
      it = scoreQ.pop_front();
      got = {fetchStall, decodeStall, decodeBubble, executeBubble};
      checks++;
      if (got !== it.ctl || fwdSelA !== it.selA || fwdSelB !== it.selB) begin
        failures++;
        $display("FAIL %s: ctl=%b selA=%0d selB=%0d expected ctl=%b selA=%0d selB=%0d",
                 it.tag, got, fwdSelA, fwdSelB, it.ctl, it.selA, it.selB);
      end
    end
  end

  initial begin
    idle();
    decIcode = 4'h1; decSrcA = 4'hF; decSrcB = 4'hF;
    exeIcode = 4'h1; exeDstE = 4'hF; exeDstM = 4'hF; exeCnd = 1'b1;
    memIcode = 4'h1; memDstE = 4'hF; memDstM = 4'hF;
    wbDstE = 4'hF; wbDstM = 4'hF;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R9 quiescent pipeline
    idle(); send(4'b0000, 3'd0, 3'd0, "R9 idle");

    // R1 load into operand A
    idle(); sEI = 4'h5; sEDM = 4'h3; sSA = 4'h3;
    send(4'b1101, 3'd0, 3'd0, "R1 load/use srcA");
    // R1 pop into operand B
    idle(); sEI = 4'hB; sEDM = 4'h2; sSB = 4'h2; sSA = 4'h6;
    send(4'b1101, 3'd0, 3'd0, "R1 pop/use srcB");

    // R2 no-register on both sides
    idle(); sEI = 4'h5; sEDM = 4'hF; sSA = 4'hF;
    send(4'b0000, 3'd0, 3'd0, "R2 load dst 0xF");
    idle(); sEDE = 4'hF; sMDM = 4'hF; sWDE = 4'hF; sSA = 4'hF; sSB = 4'hF;
    send(4'b0000, 3'd0, 3'd0, "R2 src 0xF never forwarded");

    // R3 load without match, ALU op with match
    idle(); sEI = 4'h5; sEDM = 4'h3; sSA = 4'h5; sSB = 4'h6;
    send(4'b0000, 3'd0, 3'd0, "R3 load no match");
    idle(); sEI = 4'h6; sEDE = 4'h3; sSA = 4'h3;
    send(4'b0000, 3'd1, 3'd0, "R3 ALU hazard forwarded");

    // R4 return in each of three stages
    idle(); sDI = 4'h9;
    send(4'b1010, 3'd0, 3'd0, "R4 ret in decode");
    idle(); sEI = 4'h9;
    send(4'b1010, 3'd0, 3'd0, "R4 ret in execute");
    idle(); sMI = 4'h9;
    send(4'b1010, 3'd0, 3'd0, "R4 ret in memory");

    // R5 load/use combined with return in decode
    idle(); sDI = 4'h9; sEI = 4'h5; sEDM = 4'h4; sSA = 4'h4;
    send(4'b1101, 3'd0, 3'd0, "R5 load/use with ret");

    // R6 branch outcomes
    idle(); sEI = 4'h7; sCnd = 1'b0;
    send(4'b0011, 3'd0, 3'd0, "R6 mispredict");
    idle(); sEI = 4'h7; sCnd = 1'b1;
    send(4'b0000, 3'd0, 3'd0, "R6 taken correct");
    idle(); sEI = 4'h7; sCnd = 1'b0; sDI = 4'h9;
    send(4'b1011, 3'd0, 3'd0, "R6 mispredict with ret in decode");

    // R7 priority chain on register 3
    idle(); sSA = 4'h3; sEDE = 4'h3; sMDM = 4'h3; sMDE = 4'h3; sWDM = 4'h3; sWDE = 4'h3;
    send(4'b0000, 3'd1, 3'd0, "R7 exe ALU first");
    sEDE = 4'hF;
    send(4'b0000, 3'd2, 3'd0, "R7 mem read second");
    sMDM = 4'hF;
    send(4'b0000, 3'd3, 3'd0, "R7 mem ALU third");
    sMDE = 4'hF;
    send(4'b0000, 3'd4, 3'd0, "R7 wb mem fourth");
    sWDM = 4'hF;
    send(4'b0000, 3'd5, 3'd0, "R7 wb ALU fifth");
    sWDE = 4'hF;
    send(4'b0000, 3'd0, 3'd0, "R7 register file last");

    // R8 independent operands
    idle(); sSA = 4'h1; sSB = 4'h2; sMDE = 4'h1; sWDM = 4'h2;
    send(4'b0000, 3'd3, 3'd4, "R8 split selects");
    idle(); sSA = 4'h2; sSB = 4'h2; sEDE = 4'h2;
    send(4'b0000, 3'd1, 3'd1, "R8 same source both");

    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=completed");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule